// File: doc/BRIEF.md
# Fractional-N Ratio Source Selector

This block decides which fractional-N word drives a frequency synthesizer. The word is either a static ratio from one of four programmed ratio registers or the live dynamic ratio from a digital PLL. When the static word is in use the synthesizer runs as a plain frequency synthesizer. When the dynamic word is in use the block reports hybrid mode.

Two 2-bit pointers and one source bit, all written through a small synchronous write port, decide the selection. If the two pointers are equal, the source bit picks the word by hand. If the pointers differ, the block chooses on its own. A reference input that has recent rising edges gets the dynamic word. A reference input that has gone quiet gets the static word, but only after a long hold-off counted in system-clock cycles. A presence detector works on the asynchronous reference input in the system-clock domain.

Top module: `frac_src_sel`

## Requirements
- R1: A synchronous active-low reset clears all ratio and control registers and the hold-off counter, marks the reference as absent, and drives `fracn_word`=0, `hybrid_mode`=0 and `active_ptr`=0 from the next clock edge on.
- R2: A write with `wr_en`=1 and `wr_addr` 0..3 loads `wr_data` into ratio register 0..3. Address 4 is the control register: bits [1:0] hold the ratio-select pointer, bits [3:2] hold the lock pointer and bit 4 holds the manual source bit (1 = dynamic).
- R3: When the two pointers are equal, one cycle after the inputs settle `hybrid_mode` equals the manual source bit and `active_ptr` equals the ratio-select pointer. `fracn_word` then equals `dpll_ratio` when the bit is 1 and the ratio register named by the ratio-select pointer when the bit is 0.
- R4: Automatic selection is on exactly when the pointers differ, and while it is on the manual source bit has no effect on any output.
- R5: In automatic selection with the reference present, the outputs one cycle later are `hybrid_mode`=1, `fracn_word`=`dpll_ratio` and `active_ptr`=the lock pointer.
- R6: The reference counts as present after a rising edge of `ref_in` passes a two-flop synchronizer. It counts as absent after `presence_timeout` system cycles pass with no rising edge, and this holds even while `ref_in` stays at a constant high level.
- R7: In automatic selection, once the reference is absent while the dynamic word is in use, the block keeps the dynamic word for `HOLDOFF_CYCLES` cycles. It then switches to the static word from the ratio-select register, with `active_ptr` equal to the ratio-select pointer.
- R8: If the reference returns during the hold-off, the hold-off counter restarts and the outputs stay on the dynamic word without a single cycle on the static word.
- R9: `fracn_word`, `hybrid_mode` and `active_ptr` are all updated on the same clock edge. Whenever `hybrid_mode`=0 and no register was written on the previous cycle, `fracn_word` equals the ratio register that `active_ptr` names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0..3 ratios, 4 control) |
| wr_data | input | 32 | Register write data |
| ref_in | input | 1 | Asynchronous reference input |
| presence_timeout | input | 16 | Cycles without an edge before the reference is absent |
| dpll_ratio | input | 32 | Dynamic ratio from the digital PLL |
| fracn_word | output | 32 | Selected fractional-N word |
| hybrid_mode | output | 1 | 1 = dynamic source, 0 = static source |
| active_ptr | output | 2 | Ratio register that is currently in effect |

## Verification
A corrupted pointer or source state shows up one cycle later as a wrong `active_ptr`, or as a `fracn_word` that fails to track `dpll_ratio`. A broken presence detector or hold-off counter only shows up at the switch-over. It appears as a move to the static word too early, too late, or during a returning reference, and so checks are placed on both sides of the expected switch cycle with a margin of a few synchronizer cycles. A wrong register write shows as a wrong static word on the next selection of that register.

// File: rtl/frac_src_pkg.sv
// Package: shared source encoding for the fractional-N source selector.
// Assumes: nothing beyond IEEE 1800-2017.
package frac_src_pkg;
    typedef enum logic {
        SRC_STATIC  = 1'b0,
        SRC_DYNAMIC = 1'b1
    } src_e;
endpackage

// File: rtl/frac_ratio_regs.sv
// Module: frac_ratio_regs
// Holds the ratio registers and the control register (pointers and manual
// source bit). The ratio registers sit at addresses 0..NUM_RATIOS-1 and the
// control register sits at address NUM_RATIOS. Other addresses are ignored.
// Assumes a synchronous active-low reset.
module frac_ratio_regs #(
    parameter int RATIO_W    = 32,
    parameter int NUM_RATIOS = 4,
    parameter int PTR_W      = 2,
    parameter int ADDR_W     = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [RATIO_W-1:0]                 wr_data,
    output logic [NUM_RATIOS-1:0][RATIO_W-1:0] ratio_all,
    output logic [PTR_W-1:0]                   rsel,
    output logic [PTR_W-1:0]                   lock_sel,
    output logic                               man_src
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_RATIOS);

    // One storage register per ratio slot.
    for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_ratio
        // Load slot i when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ratio_all[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(i))
                ratio_all[i] <= wr_data;
        end
    end

    // Control register: ratio-select pointer, lock pointer, manual source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsel     <= '0;
            lock_sel <= '0;
            man_src  <= 1'b0;
        end else if (wr_en && wr_addr == CTRL_ADDR) begin
            rsel     <= wr_data[PTR_W-1:0];
            lock_sel <= wr_data[2*PTR_W-1:PTR_W];
            man_src  <= wr_data[2*PTR_W];
        end
    end
endmodule

// File: rtl/frac_ref_presence.sv
// Module: frac_ref_presence
// Brings the asynchronous reference into the system-clock domain through two
// flops and detects rising edges. The reference is declared absent after
// `timeout` cycles without an edge. A constant level counts as absent.
// Assumes a synchronous active-low reset, which leaves the reference absent.
module frac_ref_presence #(
    parameter int TIMEOUT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_in,
    input  logic [TIMEOUT_W-1:0] timeout,
    output logic                 edge_seen,
    output logic                 present
);
    logic [2:0]           sync_q;
    logic [TIMEOUT_W-1:0] gap_cnt;

    // A rising edge is a 0 on the older stage and a 1 on the newer stage.
    assign edge_seen = sync_q[1] & ~sync_q[2];

    // Synchronizer chain plus edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], ref_in};
    end

    // Gap counter: an edge restarts it, and running past the timeout clears presence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
            present <= 1'b0;
        end else if (edge_seen) begin
            gap_cnt <= '0;
            present <= 1'b1;
        end else if (gap_cnt >= timeout) begin
            present <= 1'b0;
        end else begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/frac_src_ctrl.sv
// Module: frac_src_ctrl
// Picks the source and runs the hold-off timer in automatic selection.
// The word, the mode and the pointer come from one set of registers, so all
// three change on the same edge.
// Assumes a synchronous active-low reset. Reset starts on the static source.
module frac_src_ctrl
    import frac_src_pkg::*;
#(
    parameter int RATIO_W        = 32,
    parameter int NUM_RATIOS     = 4,
    parameter int PTR_W          = 2,
    parameter int HOLDOFF_CYCLES = 8388608
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               auto_en,
    input  logic                               man_src,
    input  logic                               ref_present,
    input  logic [PTR_W-1:0]                   rsel,
    input  logic [PTR_W-1:0]                   lock_sel,
    input  logic [NUM_RATIOS-1:0][RATIO_W-1:0] ratio_all,
    input  logic [RATIO_W-1:0]                 dpll_ratio,
    output logic [RATIO_W-1:0]                 word_q,
    output logic                               hybrid_q,
    output logic [PTR_W-1:0]                   ptr_q
);
    localparam int HOLD_W = $clog2(HOLDOFF_CYCLES + 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLDOFF_CYCLES - 1);

    logic [HOLD_W-1:0] hold_cnt;
    logic              hold_done;
    logic              hold_run;
    src_e              src_d;
    logic [PTR_W-1:0]  ptr_d;

    assign hold_done = (hold_cnt == HOLD_LAST);
    assign hold_run  = auto_en && !ref_present && hybrid_q;

    // Next source: manual bit, reference presence, or the end of the hold-off.
    always_comb begin
        if (!auto_en)
            src_d = src_e'(man_src);
        else if (ref_present)
            src_d = SRC_DYNAMIC;
        else if (hybrid_q && hold_done)
            src_d = SRC_STATIC;
        else
            src_d = src_e'(hybrid_q);
        ptr_d = (auto_en && src_d == SRC_DYNAMIC) ? lock_sel : rsel;
    end

    // Hold-off timer: counts only while waiting to leave the dynamic source.
    always_ff @(posedge clk) begin
        if (!rst_n || !hold_run || hold_done) hold_cnt <= '0;
        else                                  hold_cnt <= hold_cnt + 1'b1;
    end

    // Output registers, all updated together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            hybrid_q <= 1'b0;
            ptr_q    <= '0;
        end else begin
            word_q   <= (src_d == SRC_DYNAMIC) ? dpll_ratio : ratio_all[ptr_d];
            hybrid_q <= (src_d == SRC_DYNAMIC);
            ptr_q    <= ptr_d;
        end
    end
endmodule

// File: rtl/frac_src_sel.sv
// Module: frac_src_sel (top)
// Selects the fractional-N word for a synthesizer. The word is either a
// programmed static ratio or the dynamic ratio from a digital PLL, chosen by
// hand or automatically from reference presence.
// Assumes ref_in is asynchronous to clk and a synchronous active-low reset.
module frac_src_sel #(
    parameter int RATIO_W        = 32,
    parameter int NUM_RATIOS     = 4,
    parameter int TIMEOUT_W      = 16,
    parameter int HOLDOFF_CYCLES = 8388608,
    parameter int PTR_W          = $clog2(NUM_RATIOS),
    parameter int ADDR_W         = PTR_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [RATIO_W-1:0]   wr_data,
    input  logic                 ref_in,
    input  logic [TIMEOUT_W-1:0] presence_timeout,
    input  logic [RATIO_W-1:0]   dpll_ratio,
    output logic [RATIO_W-1:0]   fracn_word,
    output logic                 hybrid_mode,
    output logic [PTR_W-1:0]     active_ptr
);
    logic [NUM_RATIOS-1:0][RATIO_W-1:0] ratio_all;
    logic [PTR_W-1:0]                   rsel;
    logic [PTR_W-1:0]                   lock_sel;
    logic                               man_src;
    logic                               edge_seen;
    logic                               ref_present;
    logic                               auto_en;

    // Automatic selection is on whenever the two pointers disagree.
    assign auto_en = (lock_sel != rsel);

    frac_ratio_regs #(
        .RATIO_W(RATIO_W), .NUM_RATIOS(NUM_RATIOS), .PTR_W(PTR_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ratio_all(ratio_all), .rsel(rsel),
        .lock_sel(lock_sel), .man_src(man_src)
    );

    frac_ref_presence #(.TIMEOUT_W(TIMEOUT_W)) u_pres (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .timeout(presence_timeout),
        .edge_seen(edge_seen), .present(ref_present)
    );

    frac_src_ctrl #(
        .RATIO_W(RATIO_W), .NUM_RATIOS(NUM_RATIOS), .PTR_W(PTR_W),
        .HOLDOFF_CYCLES(HOLDOFF_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .man_src(man_src),
        .ref_present(ref_present), .rsel(rsel), .lock_sel(lock_sel),
        .ratio_all(ratio_all), .dpll_ratio(dpll_ratio),
        .word_q(fracn_word), .hybrid_q(hybrid_mode), .ptr_q(active_ptr)
    );
endmodule

// File: rtl/frac_src_sel_chk.sv
// Module: frac_src_sel_chk
// Assertion checker bound to frac_src_sel. It watches the registers, the
// presence detector and the output registers.
module frac_src_sel_chk #(
    parameter int RATIO_W    = 32,
    parameter int NUM_RATIOS = 4,
    parameter int PTR_W      = 2
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               wr_en,
    input logic                               auto_en,
    input logic                               man_src,
    input logic                               ref_present,
    input logic                               edge_seen,
    input logic [PTR_W-1:0]                   rsel,
    input logic [PTR_W-1:0]                   lock_sel,
    input logic [NUM_RATIOS-1:0][RATIO_W-1:0] ratio_all,
    input logic [RATIO_W-1:0]                 fracn_word,
    input logic                               hybrid_mode,
    input logic [PTR_W-1:0]                   active_ptr
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!hybrid_mode && active_ptr == '0 && fracn_word == '0));

    // R3
    manual_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> (hybrid_mode == $past(man_src) && active_ptr == $past(rsel)));

    // R5
    auto_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && ref_present) |=> (hybrid_mode && active_ptr == $past(lock_sel)));

    // R6
    presence_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_present) |-> $past(edge_seen));

    // R7
    leave_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hybrid_mode) && $past(auto_en)) |-> !$past(ref_present));

    // R9
    static_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hybrid_mode && !$past(wr_en)) |-> fracn_word == ratio_all[active_ptr]);
endmodule

bind frac_src_sel frac_src_sel_chk #(
    .RATIO_W(RATIO_W), .NUM_RATIOS(NUM_RATIOS), .PTR_W(PTR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .auto_en(auto_en),
    .man_src(man_src), .ref_present(ref_present), .edge_seen(edge_seen),
    .rsel(rsel), .lock_sel(lock_sel), .ratio_all(ratio_all),
    .fracn_word(fracn_word), .hybrid_mode(hybrid_mode), .active_ptr(active_ptr)
);

// File: tb/sim_frac_src_sel.sv
// Bench for frac_src_sel. It mixes seeded random manual-mode traffic with
// directed checks of automatic selection, hold-off and presence timing.
module sim_frac_src_sel;
    localparam int HOLD = 100;
    localparam int TMO  = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        ref_in = 1'b0;
    logic [15:0] presence_timeout = 16'(TMO);
    logic [31:0] dpll_ratio = '0;
    logic [31:0] fracn_word;
    logic        hybrid_mode;
    logic [1:0]  active_ptr;

    logic        ref_run = 1'b0;
    logic        ref_idle = 1'b0;
    logic [31:0] m_ratio [4];
    int          n_chk = 0;
    int          n_err = 0;

    frac_src_sel #(.HOLDOFF_CYCLES(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ref_in(ref_in), .presence_timeout(presence_timeout),
        .dpll_ratio(dpll_ratio), .fracn_word(fracn_word),
        .hybrid_mode(hybrid_mode), .active_ptr(active_ptr)
    );

    always #5 clk = ~clk;

    // Reference generator: toggles every 30 ns while running, else idles at a level.
    initial forever begin
        #30;
        if (ref_run) ref_in = ~ref_in;
        else         ref_in = ref_idle;
    end

    function automatic logic [31:0] exp_manual(logic m, logic [1:0] sel, logic [31:0] d);
        return m ? d : m_ratio[sel];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ctrl(logic [1:0] rs, logic [1:0] lk, logic m);
        wr(3'd4, {27'd0, m, lk, rs});
    endtask

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #1_500_000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5A17));
        cycles(3);
        // R1 reset state
        chk("R1 word", fracn_word, 0);
        chk("R1 mode", 32'(hybrid_mode), 0);
        chk("R1 ptr", 32'(active_ptr), 0);
        rst_n = 1'b1;

        // R2 load ratios, then select slot 2 by hand on the static source
        for (int i = 0; i < 4; i++) begin
            m_ratio[i] = $urandom;
            wr(3'(i), m_ratio[i]);
        end
        ctrl(2'd2, 2'd2, 1'b0);
        @(negedge clk);
        chk("R2 static word", fracn_word, m_ratio[2]);
        chk("R3 manual mode", 32'(hybrid_mode), 0);
        chk("R3 manual ptr", 32'(active_ptr), 2);

        // R3 random manual traffic
        for (int it = 0; it < 40; it++) begin
            logic [1:0] s;
            logic m;
            s = 2'($urandom_range(0, 3));
            m = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 3) == 0) begin
                m_ratio[s] = $urandom;
                wr(3'(s), m_ratio[s]);
            end
            ctrl(s, s, m);
            dpll_ratio = $urandom;
            @(negedge clk);
            chk("R3 manual word", fracn_word, exp_manual(m, s, dpll_ratio));
            chk("R3 manual mode", 32'(hybrid_mode), 32'(m));
            chk("R3 manual ptr", 32'(active_ptr), 32'(s));
        end

        // R4 automatic, reference absent, manual bit set but ignored
        ctrl(2'd1, 2'd1, 1'b0);
        @(negedge clk);
        ctrl(2'd1, 2'd3, 1'b1);
        @(negedge clk);
        chk("R4 ignored mode", 32'(hybrid_mode), 0);
        chk("R4 ignored word", fracn_word, m_ratio[1]);
        chk("R4 ptr", 32'(active_ptr), 1);

        // R5/R6 reference appears: dynamic word on lock pointer
        ref_run = 1'b1;
        cycles(20);
        chk("R6 present mode", 32'(hybrid_mode), 1);
        chk("R5 ptr", 32'(active_ptr), 3);
        for (int it = 0; it < 8; it++) begin
            dpll_ratio = $urandom;
            @(negedge clk);
            chk("R5 dyn word", fracn_word, dpll_ratio);
        end

        // R4 flipping the manual bit in automatic selection does nothing
        ctrl(2'd1, 2'd3, 1'b0);
        @(negedge clk);
        chk("R4 ignored flip", 32'(hybrid_mode), 1);
        chk("R4 ignored word", fracn_word, dpll_ratio);

        // R7 reference lost: stays dynamic until the hold-off ends
        ref_idle = 1'b0;
        ref_run = 1'b0;
        cycles(TMO + HOLD - 15);
        chk("R7 still dynamic", 32'(hybrid_mode), 1);
        cycles(30);
        chk("R7 static mode", 32'(hybrid_mode), 0);
        chk("R7 static word", fracn_word, m_ratio[1]);
        chk("R7 static ptr", 32'(active_ptr), 1);

        // R8 reference returns during the hold-off
        ref_run = 1'b1;
        cycles(30);
        chk("R8 reacquired", 32'(hybrid_mode), 1);
        ref_run = 1'b0;
        cycles(TMO + HOLD / 2);
        ref_run = 1'b1;
        begin
            int low = 0;
            for (int i = 0; i < 2 * HOLD; i++) begin
                @(negedge clk);
                if (!hybrid_mode) low++;
            end
            chk("R8 no static cycles", 32'(low), 0);
        end

        // R6 constant high level without edges counts as absent
        ref_idle = 1'b1;
        ref_run = 1'b0;
        cycles(TMO + HOLD + 40);
        chk("R6 level absent", 32'(hybrid_mode), 0);
        chk("R6 level word", fracn_word, m_ratio[1]);

        // R1 reset in mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        cycles(2);
        chk("R1 re-reset mode", 32'(hybrid_mode), 0);
        chk("R1 re-reset ptr", 32'(active_ptr), 0);
        chk("R1 re-reset word", fracn_word, 0);
        rst_n = 1'b1;
        cycles(2);
        finish_run();
    end
endmodule